// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block produces all refresh traffic for an asynchronous 1M x 1 dynamic memory. After reset it holds the memory strobes idle for a fixed power-up wait. It then owes a fixed burst of warm-up refreshes, and `init_done` goes high once they have all completed. From that point an interval timer adds one owed refresh per retention slot, so that 512 rows are covered inside the retention window. Owed refreshes sit in a saturating backlog counter. Each one is requested from an external access arbiter. Once the grant arrives, the block drives one strobe sequence, and `ref_done` pulses when that sequence ends.

Two sequences are available, chosen by `ras_only_mode` at the moment of grant:
- **CAS-first refresh.** Column strobe falls first. Row strobe falls while column strobe stays low. The memory supplies the row internally.
- **Row-strobe-only refresh.** The address bus carries a row taken from an internal 9-bit row counter, and column strobe stays high.

All timing values are parameters counted in clock cycles. The defaults assume a 10 ns clock.

States and transitions:
- **PWRUP** is the reset state. It moves to **IDLE** when the power-up timer expires, and at that moment the backlog is loaded with the warm-up count.
- **IDLE** moves to **REQ** when the backlog is non-zero.
- **REQ** holds `ref_req` high. On grant it goes to **CBR_LEAD** (CAS-first) or **ROW_SETUP** (row-strobe-only).
- **CBR_LEAD** drops column strobe for the lead time, then goes to **RAS_ACT**.
- **ROW_SETUP** drives the row address for one cycle, then goes to **RAS_ACT**.
- **RAS_ACT** holds row strobe low for the active width, then goes to **PRECHG**.
- **PRECHG** holds both strobes high for the precharge time. On its last cycle it pulses `ref_done`. It returns to **REQ** when more than one refresh is still owed, and to **IDLE** otherwise.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and directly after it, `ras_n` and `cas_n` are 1, `addr_oe` and `ref_req` are 0, `init_done` is 0.
- R2: `ref_req` stays 0 for at least PWRUP_CYC cycles after reset release and rises within PWRUP_CYC+3 cycles (grant held high).
- R3: After power-up exactly INIT_REFRESHES refreshes are owed; `init_done` is 0 in the cycle of the last warm-up `ref_done` pulse, is 1 from the next cycle, and never falls until reset.
- R4: In a CAS-first refresh (`cas_n`=0 when `ras_n` falls), `cas_n` is low for at least CSR_CYC cycles before `ras_n` falls and stays low for the whole time `ras_n` is low (at least CHR_CYC cycles).
- R5: `ras_n` stays low for at least RAS_CYC cycles per refresh and stays high for at least RP_CYC cycles between two refreshes.
- R6: In a row-strobe-only refresh `addr_oe` is 1 from at least one cycle before `ras_n` falls until `ras_n` rises, and `cas_n` stays 1 throughout.
- R7: The row driven on `row_addr` equals the number of refreshes completed since reset, modulo 512; bit 9 of `row_addr` is 0.
- R8: `ref_req` stays high from request to completion, the strobes stay idle while the grant is low, and `ref_done` is a single-cycle pulse on the last precharge cycle with both strobes high.
- R9: After `init_done`, one refresh is owed every INTERVAL_CYC cycles; with the grant held high, consecutive `ref_done` pulses are INTERVAL_CYC cycles apart.
- R10: Refreshes that come due while the grant is low accumulate and are then served back to back with `ref_req` never dropping between them; the backlog saturates at 2^PEND_W-1.
- R11: `ras_only_mode` is sampled only on the grant cycle; changing it during a sequence does not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only_mode | input | 1 | 1 selects row-strobe-only refresh, 0 selects CAS-first |
| ref_gnt | input | 1 | Arbiter grant for the memory strobes |
| ref_req | output | 1 | Refresh request, held until completion |
| ref_done | output | 1 | One-cycle pulse when a refresh completes |
| init_done | output | 1 | High once the warm-up refreshes have completed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | High while `row_addr` must drive the address bus |
| row_addr | output | 10 | Row address for row-strobe-only refresh, zero otherwise |

## Verification
The assertions check the following on every cycle:
- no request appears before the power-up wait has elapsed;
- column strobe already leads a row-strobe fall in a CAS-first refresh;
- column strobe stays high during a row-strobe-only refresh;
- the strobes stay idle outside a request;
- the row-strobe width is held;
- `init_done` never falls.

Some behaviour can only be shown by the bench scenarios:
- the exact count of warm-up refreshes;
- the spacing of periodic refreshes;
- the backlog accumulating while the grant is withheld and then draining back to back;
- its saturation value;
- the row sequence modulo 512;
- the fact that a mode change in mid-sequence is ignored.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_REQ,
        ST_CBR_LEAD,
        ST_ROW_SETUP,
        ST_RAS_ACT,
        ST_PRECHG
    } ref_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else if (en)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
    parameter int PEND_W = 4,
    parameter int INIT_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_init,
    input  logic              owe,
    input  logic              paid,
    output logic [PEND_W-1:0] pend
);
    localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (load_init)
            pend <= PEND_W'(INIT_N);
        else if (owe && !paid && pend != PMAX)
            pend <= pend + 1'b1;
        else if (paid && !owe && pend != '0)
            pend <= pend - 1'b1;
    end
endmodule

// File: rtl/refsched_rowctr.sv
module refsched_rowctr #(
    parameter int ROW_W  = 9,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              oe,
    output logic [ADDR_W-1:0] addr
);
    logic [ROW_W-1:0] row;

    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (step)
            row <= row + 1'b1;
    end

    assign addr = oe ? {{(ADDR_W - ROW_W){1'b0}}, row} : '0;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refsched_pkg::*;
#(
    parameter int PWRUP_CYC      = 10000,
    parameter int INIT_REFRESHES = 8,
    parameter int INTERVAL_CYC   = 1560,
    parameter int CSR_CYC        = 1,
    parameter int CHR_CYC        = 3,
    parameter int RAS_CYC        = 8,
    parameter int RP_CYC         = 6,
    parameter int RAH_CYC        = 2,
    parameter int PEND_W         = 4,
    parameter int ROW_W          = 9,
    parameter int ADDR_W         = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_only_mode,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ref_done,
    output logic              init_done,
    output logic              ras_n,
    output logic              cas_n,
    output logic              addr_oe,
    output logic [ADDR_W-1:0] row_addr
);
    localparam int RAS_LOW = imax(imax(RAS_CYC, CHR_CYC), RAH_CYC);
    localparam int PH_MAX  = imax(imax(RAS_LOW, RP_CYC), CSR_CYC);
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int IC_W    = $clog2(INIT_REFRESHES + 1);

    ref_state_t        state, state_nx;
    logic [PH_W-1:0]   ph;
    logic              mode_q;
    logic [PEND_W-1:0] pend;
    logic [IC_W-1:0]   init_cnt;
    logic              pwr_tick, slot_tick;

    refsched_interval #(.PERIOD(PWRUP_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .en(state == ST_PWRUP), .tick(pwr_tick)
    );

    refsched_interval #(.PERIOD(INTERVAL_CYC)) u_slot (
        .clk(clk), .rst_n(rst_n), .en(init_done), .tick(slot_tick)
    );

    refsched_backlog #(.PEND_W(PEND_W), .INIT_N(INIT_REFRESHES)) u_pend (
        .clk(clk), .rst_n(rst_n), .load_init(pwr_tick),
        .owe(slot_tick), .paid(ref_done), .pend(pend)
    );

    refsched_rowctr #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_row (
        .clk(clk), .rst_n(rst_n), .step(ref_done), .oe(addr_oe), .addr(row_addr)
    );

    function automatic logic [PH_W-1:0] ph_load(input ref_state_t s);
        unique case (s)
            ST_CBR_LEAD: return PH_W'(CSR_CYC - 1);
            ST_RAS_ACT:  return PH_W'(RAS_LOW - 1);
            ST_PRECHG:   return PH_W'(RP_CYC - 1);
            default:     return '0;
        endcase
    endfunction

    // state register, phase timer, mode capture and warm-up count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_PWRUP;
            ph       <= '0;
            mode_q   <= 1'b0;
            init_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state)
                ph <= ph_load(state_nx);
            else if (ph != '0)
                ph <= ph - 1'b1;
            if (state == ST_REQ && ref_gnt)
                mode_q <= ras_only_mode;
            if (ref_done && !init_done)
                init_cnt <= init_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWRUP:     if (pwr_tick) state_nx = ST_IDLE;
            ST_IDLE:      if (pend != '0) state_nx = ST_REQ;
            ST_REQ:       if (ref_gnt)
                              state_nx = ras_only_mode ? ST_ROW_SETUP : ST_CBR_LEAD;
            ST_CBR_LEAD:  if (ph == '0) state_nx = ST_RAS_ACT;
            ST_ROW_SETUP: state_nx = ST_RAS_ACT;
            ST_RAS_ACT:   if (ph == '0) state_nx = ST_PRECHG;
            ST_PRECHG:    if (ph == '0)
                              state_nx = (pend > PEND_W'(1)) ? ST_REQ : ST_IDLE;
            default:      state_nx = ST_PWRUP;
        endcase
    end

    // Moore outputs
    always_comb begin
        ref_req  = 1'b0;
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        addr_oe  = 1'b0;
        ref_done = 1'b0;
        unique case (state)
            ST_PWRUP, ST_IDLE: ;
            ST_REQ:       ref_req = 1'b1;
            ST_CBR_LEAD: begin
                ref_req = 1'b1;
                cas_n   = 1'b0;
            end
            ST_ROW_SETUP: begin
                ref_req = 1'b1;
                addr_oe = 1'b1;
            end
            ST_RAS_ACT: begin
                ref_req = 1'b1;
                ras_n   = 1'b0;
                cas_n   = mode_q;
                addr_oe = mode_q;
            end
            ST_PRECHG: begin
                ref_req  = 1'b1;
                ref_done = (ph == '0);
            end
            default: ;
        endcase
    end

    assign init_done = (init_cnt == IC_W'(INIT_REFRESHES));
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
    parameter int PWRUP_CYC = 10000,
    parameter int RAS_CYC   = 8
) (
    input logic clk,
    input logic rst_n,
    input logic ref_req,
    input logic ref_done,
    input logic init_done,
    input logic ras_n,
    input logic cas_n,
    input logic addr_oe
);
    localparam int SW = $clog2(PWRUP_CYC + 2);
    localparam int LW = $clog2(RAS_CYC + 2);

    logic [SW-1:0] since_rst;
    logic [LW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            lo_cnt    <= '0;
        end else begin
            if (since_rst != SW'(PWRUP_CYC))
                since_rst <= since_rst + 1'b1;
            if (ras_n)
                lo_cnt <= '0;
            else if (lo_cnt != LW'(RAS_CYC + 1))
                lo_cnt <= lo_cnt + 1'b1;
        end
    end

    a_r2_quiet_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> since_rst >= SW'(PWRUP_CYC));

    a_r4_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    a_r5_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> lo_cnt >= LW'(RAS_CYC));

    a_r6_rasonly_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && addr_oe) |-> cas_n);

    a_r8_done_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> (ras_n && cas_n && ref_req));

    a_r8_no_strobe_unrequested: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req |-> (ras_n && cas_n && !addr_oe));

    a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

bind dram_refresh_sched refsched_chk #(
    .PWRUP_CYC(PWRUP_CYC),
    .RAS_CYC(RAS_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_done(ref_done),
    .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
    localparam int PWRUP    = 20;
    localparam int INIT_N   = 8;
    localparam int INTERVAL = 300;
    localparam int CSR      = 1;
    localparam int CHR      = 3;
    localparam int RASW     = 8;
    localparam int RP       = 6;
    localparam int PMAX     = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       gnt = 1'b1;
    logic       req, done, initd, ras_n, cas_n, oe;
    logic [9:0] raddr;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    dram_refresh_sched #(
        .PWRUP_CYC(PWRUP), .INIT_REFRESHES(INIT_N), .INTERVAL_CYC(INTERVAL),
        .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASW), .RP_CYC(RP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ras_only_mode(mode), .ref_gnt(gnt),
        .ref_req(req), .ref_done(done), .init_done(initd),
        .ras_n(ras_n), .cas_n(cas_n), .addr_oe(oe), .row_addr(raddr)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // strobe monitor: R4 R5 R6 R7
    logic prev_ras = 1'b1;
    bit   seen_low = 1'b0;
    bit   cbr_cyc  = 1'b0;
    int   hi_len = 0, lo_len = 0, cas_lead = 0, cas_lo_in = 0, bad_ro = 0, dn = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                if (seen_low) chk(hi_len >= RP, "R5 precharge", hi_len, RP);
                cbr_cyc = !cas_n;
                if (cbr_cyc)
                    chk(cas_lead >= CSR, "R4 cas lead", cas_lead, CSR);
                else
                    chk(oe && raddr == 10'(dn % 512), "R7 row addr", int'(raddr), dn % 512);
                lo_len = 1; cas_lo_in = !cas_n ? 1 : 0;
                bad_ro = (!cbr_cyc && (!cas_n || !oe)) ? 1 : 0;
                seen_low = 1'b1;
            end else if (!prev_ras && ras_n) begin
                chk(lo_len >= RASW, "R5 ras width", lo_len, RASW);
                if (cbr_cyc)
                    chk(cas_lo_in == lo_len && lo_len >= CHR, "R4 cas hold", cas_lo_in, lo_len);
                else
                    chk(bad_ro == 0, "R6 ras-only strobe/oe", bad_ro, 0);
                hi_len = 1;
            end else if (!ras_n) begin
                lo_len++;
                if (!cas_n) cas_lo_in++;
                if (!cbr_cyc && (!cas_n || !oe)) bad_ro++;
            end else begin
                hi_len++;
            end
            if (ras_n) cas_lead = cas_n ? 0 : cas_lead + 1;
            if (done) dn++;
            prev_ras = ras_n;
        end
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && !oe && !req && !initd, "R1 reset outputs",
            {ras_n, cas_n, oe, req, initd}, 5'b11000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && !req && !initd, "R1 after release",
            {ras_n, cas_n, req, initd}, 4'b1100);
    endtask

    task automatic t_pwrup();
        int k = 1;
        while (!req && k < PWRUP + 10) begin
            @(negedge clk);
            k++;
        end
        chk(k >= PWRUP && k <= PWRUP + 3, "R2 first request cycle", k, PWRUP);
    endtask

    task automatic t_init();
        int cnt = 0;
        int early = 0;
        while (cnt < INIT_N) begin
            @(negedge clk);
            if (done) begin
                cnt++;
                if (initd) early++;
            end
        end
        chk(early == 0, "R3 init_done low during warm-up", early, 0);
        @(negedge clk);
        chk(initd == 1'b1, "R3 init_done after last warm-up", initd, 1);
    endtask

    task automatic t_period();
        int gap = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        gap = 1;
        while (!done) begin
            @(negedge clk);
            gap++;
        end
        chk(gap == INTERVAL, "R9 refresh spacing", gap, INTERVAL);
    endtask

    task automatic t_rasonly();
        @(negedge clk);
        mode = 1'b1;
        repeat (2) begin
            while (ras_n) @(negedge clk);
            chk(cas_n && oe && raddr[9] == 1'b0, "R6 R7 ras-only drive",
                {cas_n, oe, raddr[9]}, 3'b110);
            while (!done) @(negedge clk);
            @(negedge clk);
        end
        mode = 1'b0;
    endtask

    task automatic t_mode_switch();
        while (ras_n) @(negedge clk);
        chk(!cas_n && !oe, "R11 cbr started", {cas_n, oe}, 0);
        mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!ras_n && !cas_n && !oe, "R11 mode change ignored",
            {ras_n, cas_n, oe}, 0);
        while (!done) @(negedge clk);
        mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_backlog(input int wait_cyc, input int exp_n, input string rq);
        int idle_bad = 0;
        int cnt = 0;
        while (req) @(negedge clk);
        gnt = 1'b0;
        while (!req) @(negedge clk);
        repeat (wait_cyc) begin
            @(negedge clk);
            if (!ras_n || !cas_n || !req) idle_bad++;
        end
        chk(idle_bad == 0, "R8 idle while grant low", idle_bad, 0);
        gnt = 1'b1;
        while (req) begin
            @(negedge clk);
            if (done) cnt++;
        end
        chk(cnt == exp_n, rq, cnt, exp_n);
    endtask

    initial begin
        t_reset();
        t_pwrup();
        t_init();
        t_period();
        t_rasonly();
        t_mode_switch();
        t_backlog(2 * INTERVAL + 20, 3, "R10 back-to-back backlog");
        t_backlog(16 * INTERVAL + 10, PMAX, "R10 backlog saturation");
        chk(dn > 0, "R7 refreshes counted", dn, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule